// File: doc/BRIEF.md
# Program-Priority Shared Bus Sequencer

This block runs one external bus that is shared by program memory and data memory. The bus has a 16-bit address path and a 16-bit data path. Each bus sequence opens with an instruction fetch that finishes in a single cycle. When the core also wants a data transfer, the sequence grows. An idle cycle comes first, then the data phase, then a second idle cycle. The data phase can be stretched by a programmable wait count of 0 to 7. A program-memory write can take the place of the fetch. It holds the core for a fixed three cycles.

The block drives the memory strobes, the address, the outgoing data and the pad output enable. It gives the core a stall signal and returns read data with a one-cycle valid pulse. Requests are sampled only on a sequence-start edge. This is the first rising edge after the last cycle of a sequence, and also the first edge after reset. All outputs are registered, so each bus cycle appears on the outputs one clock after the edge that decided it.

Top module: `progbus_seq`

## Requirements
- R1: After reset the stall output is high, every strobe, the output enable and rd_valid are low, and the data wait count register holds 7.
- R2: On a sequence-start edge with no program write and no data request sampled, the next cycle is a single fetch cycle. In that cycle prog_rd is high, ext_addr equals the sampled fetch_addr and core_stall is low. The edge that ends this cycle is again a sequence-start edge.
- R3: When dacc_req is sampled high (and pwr_req low) on a sequence-start edge, the sequence runs as fetch, idle, data phase, idle. No strobe is high in the idle cycles. data_rd (dacc_we=0) or data_wr (dacc_we=1) is high for the whole data phase.
- R4: The data phase lasts N+1 cycles. N is the value the wait count register holds at the edge that ends the first idle cycle. A ws_we pulse loads ws_val into that register at the next edge.
- R5: core_stall is high from the first idle cycle through the second idle cycle, and it is low in every fetch cycle.
- R6: When pwr_req is sampled high on a sequence-start edge, the sequence is four cycles with prog_wr high and ext_addr equal to fetch_addr. core_stall is high in the first three of those cycles and low in the fourth. A data request sampled on the same edge is dropped.
- R7: ext_doe is high only during a data-write phase and during a program write. In those cycles ext_dout carries dacc_wdata or pwr_data. ext_doe is low in fetch and idle cycles.
- R8: On a data read, rd_data takes the ext_din value present in the last data-phase cycle. rd_valid is high for exactly the one following cycle, the second idle cycle.
- R9: At most one of prog_rd, prog_wr, data_rd, data_wr is high in any cycle. During the data phase ext_addr equals the sampled dacc_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_addr | input | 16 | Program address for the next fetch or program write |
| pwr_req | input | 1 | Program write request for the next sequence |
| pwr_data | input | 16 | Program write data |
| dacc_req | input | 1 | Data access request for the next sequence |
| dacc_we | input | 1 | 1 = data write, 0 = data read |
| dacc_addr | input | 16 | Data access address |
| dacc_wdata | input | 16 | Data write value |
| ws_we | input | 1 | Load the data wait count |
| ws_val | input | 3 | New data wait count |
| ext_din | input | 16 | Data from the external pads |
| ext_addr | output | 16 | External address |
| ext_dout | output | 16 | Data toward the external pads |
| ext_doe | output | 1 | Pad output enable |
| prog_rd | output | 1 | Program memory read strobe |
| prog_wr | output | 1 | Program memory write strobe |
| data_rd | output | 1 | Data memory read strobe |
| data_wr | output | 1 | Data memory write strobe |
| core_stall | output | 1 | Hold the core |
| rd_data | output | 16 | Captured read data |
| rd_valid | output | 1 | One-cycle pulse with rd_data |

## Verification
The assertions check several properties on every cycle. Only one strobe may be high at a time. The pads are enabled only with a write strobe. A fetch never stalls. The read-valid pulse lasts one cycle. An idle cycle always leads into the data phase. The data phase never runs past eight cycles. A program write never runs past its fourth cycle. Properties that depend on sampled values need the bench's reference model, which walks a queue of expected cycles. These are the exact phase length for each programmed wait count, the timing of a wait-count change, the dropping of a data request beside a program write, and the address, write data and captured read data in each phase.

// File: rtl/progbus_pkg.sv
package progbus_pkg;
  typedef enum logic [2:0] {
    PB_FETCH  = 3'd0,
    PB_IDLE1  = 3'd1,
    PB_DATA   = 3'd2,
    PB_IDLE2  = 3'd3,
    PB_PWRITE = 3'd4
  } pb_state_e;
endpackage

// File: rtl/pbs_wait_cfg.sv
module pbs_wait_cfg #(
  parameter int WSW    = 3,
  parameter int WS_RST = 7
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [WSW-1:0] wval,
  output logic [WSW-1:0] ws_q
);
  always_ff @(posedge clk) begin
    if (rst) ws_q <= WSW'(WS_RST);
    else if (we) ws_q <= wval;
  end

  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (rst)
    we |=> (ws_q == $past(wval))); // R4
endmodule

// File: rtl/pbs_req.sv
module pbs_req #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic          pwr_req,
  input  logic          dacc_req,
  input  logic          dacc_we,
  input  logic [AW-1:0] dacc_addr,
  input  logic [DW-1:0] dacc_wdata,
  input  logic [AW-1:0] fetch_addr,
  input  logic [DW-1:0] pwr_data,
  output logic          dpend_q,
  output logic          dwe_q,
  output logic          dpend_n,
  output logic          dwe_n,
  output logic [AW-1:0] daddr_n,
  output logic [DW-1:0] dwdata_n,
  output logic [AW-1:0] paddr_n,
  output logic [DW-1:0] pwdata_n
);
  logic [AW-1:0] daddr_q, paddr_q;
  logic [DW-1:0] dwdata_q, pwdata_q;

  always_comb begin
    dpend_n  = take ? (dacc_req & ~pwr_req) : dpend_q;
    dwe_n    = take ? dacc_we    : dwe_q;
    daddr_n  = take ? dacc_addr  : daddr_q;
    dwdata_n = take ? dacc_wdata : dwdata_q;
    paddr_n  = take ? fetch_addr : paddr_q;
    pwdata_n = take ? pwr_data   : pwdata_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dpend_q  <= 1'b0;
      dwe_q    <= 1'b0;
      daddr_q  <= '0;
      dwdata_q <= '0;
      paddr_q  <= '0;
      pwdata_q <= '0;
    end else begin
      dpend_q  <= dpend_n;
      dwe_q    <= dwe_n;
      daddr_q  <= daddr_n;
      dwdata_q <= dwdata_n;
      paddr_q  <= paddr_n;
      pwdata_q <= pwdata_n;
    end
  end
endmodule

// File: rtl/pbs_fsm.sv
module pbs_fsm
  import progbus_pkg::*;
#(
  parameter int WSW      = 3,
  parameter int PW_WAITS = 3,
  localparam int PWB     = $clog2(PW_WAITS + 1),
  localparam int CW      = (WSW > PWB) ? WSW : PWB
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pwr_req,
  input  logic           dpend_q,
  input  logic [WSW-1:0] ws_q,
  output pb_state_e      st_q,
  output pb_state_e      st_n,
  output logic [CW-1:0]  cnt_q,
  output logic [CW-1:0]  cnt_n,
  output logic           take
);
  always_comb begin
    take = ((st_q == PB_FETCH) && !dpend_q) || (st_q == PB_IDLE2) ||
           ((st_q == PB_PWRITE) && (cnt_q == CW'(PW_WAITS)));
    st_n  = st_q;
    cnt_n = cnt_q;
    if (take) begin
      st_n  = pwr_req ? PB_PWRITE : PB_FETCH;
      cnt_n = '0;
    end else begin
      case (st_q)
        PB_FETCH:  st_n = PB_IDLE1;
        PB_IDLE1: begin
          st_n  = PB_DATA;
          cnt_n = CW'(ws_q);
        end
        PB_DATA: begin
          if (cnt_q == '0) st_n = PB_IDLE2;
          else cnt_n = cnt_q - 1'b1;
        end
        PB_PWRITE: cnt_n = cnt_q + 1'b1;
        default:   st_n = PB_IDLE2;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= PB_IDLE2;
      cnt_q <= '0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
    end
  end

  AST_IDLE1_TO_DATA: assert property (@(posedge clk) disable iff (rst)
    (st_q == PB_IDLE1) |=> (st_q == PB_DATA)); // R3
  AST_PW_LEN: assert property (@(posedge clk) disable iff (rst)
    ((st_q == PB_PWRITE) && (cnt_q == CW'(PW_WAITS))) |=> ((st_q != PB_PWRITE) || (cnt_q == '0))); // R6
endmodule

// File: rtl/pbs_drive.sv
module pbs_drive
  import progbus_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int WSW      = 3,
  parameter int PW_WAITS = 3,
  parameter int CW       = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  pb_state_e     st_q,
  input  pb_state_e     st_n,
  input  logic [CW-1:0] cnt_q,
  input  logic [CW-1:0] cnt_n,
  input  logic          dwe_q,
  input  logic          dwe_n,
  input  logic [AW-1:0] daddr_n,
  input  logic [DW-1:0] dwdata_n,
  input  logic [AW-1:0] paddr_n,
  input  logic [DW-1:0] pwdata_n,
  input  logic [DW-1:0] ext_din,
  output logic [AW-1:0] ext_addr,
  output logic [DW-1:0] ext_dout,
  output logic          ext_doe,
  output logic          prog_rd,
  output logic          prog_wr,
  output logic          data_rd,
  output logic          data_wr,
  output logic          core_stall,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  logic in_dseq_n, pw_n, dphase_n, last_rd;

  always_comb begin
    in_dseq_n = (st_n == PB_IDLE1) || (st_n == PB_DATA) || (st_n == PB_IDLE2);
    pw_n      = (st_n == PB_PWRITE);
    dphase_n  = (st_n == PB_DATA);
    last_rd   = (st_q == PB_DATA) && !dwe_q && (cnt_q == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_addr   <= '0;
      ext_dout   <= '0;
      ext_doe    <= 1'b0;
      prog_rd    <= 1'b0;
      prog_wr    <= 1'b0;
      data_rd    <= 1'b0;
      data_wr    <= 1'b0;
      core_stall <= 1'b1;
      rd_data    <= '0;
      rd_valid   <= 1'b0;
    end else begin
      ext_addr   <= in_dseq_n ? daddr_n : paddr_n;
      ext_dout   <= pw_n ? pwdata_n : dwdata_n;
      ext_doe    <= pw_n || (dphase_n && dwe_n);
      prog_rd    <= (st_n == PB_FETCH);
      prog_wr    <= pw_n;
      data_rd    <= dphase_n && !dwe_n;
      data_wr    <= dphase_n && dwe_n;
      core_stall <= in_dseq_n || (pw_n && (cnt_n < CW'(PW_WAITS)));
      rd_valid   <= last_rd;
      if (last_rd) rd_data <= ext_din;
    end
  end

  logic [WSW:0] dlen;
  always_ff @(posedge clk) begin
    if (rst) dlen <= '0;
    else if (data_rd || data_wr) dlen <= dlen + 1'b1;
    else dlen <= '0;
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({prog_rd, prog_wr, data_rd, data_wr})); // R9
  AST_DOE_SRC: assert property (@(posedge clk) disable iff (rst)
    ext_doe |-> (data_wr || prog_wr)); // R7
  AST_FETCH_FREE: assert property (@(posedge clk) disable iff (rst)
    prog_rd |-> !core_stall); // R5
  AST_RV_PULSE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid); // R8
  AST_DATA_MAX: assert property (@(posedge clk) disable iff (rst)
    (data_rd || data_wr) |-> (dlen < (WSW+1)'(2**WSW))); // R4
endmodule

// File: rtl/progbus_seq.sv
module progbus_seq
  import progbus_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int WSW      = 3,
  parameter int WS_RST   = 7,
  parameter int PW_WAITS = 3,
  localparam int PWB     = $clog2(PW_WAITS + 1),
  localparam int CW      = (WSW > PWB) ? WSW : PWB
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [AW-1:0]  fetch_addr,
  input  logic           pwr_req,
  input  logic [DW-1:0]  pwr_data,
  input  logic           dacc_req,
  input  logic           dacc_we,
  input  logic [AW-1:0]  dacc_addr,
  input  logic [DW-1:0]  dacc_wdata,
  input  logic           ws_we,
  input  logic [WSW-1:0] ws_val,
  input  logic [DW-1:0]  ext_din,
  output logic [AW-1:0]  ext_addr,
  output logic [DW-1:0]  ext_dout,
  output logic           ext_doe,
  output logic           prog_rd,
  output logic           prog_wr,
  output logic           data_rd,
  output logic           data_wr,
  output logic           core_stall,
  output logic [DW-1:0]  rd_data,
  output logic           rd_valid
);
  logic [WSW-1:0] ws_q;
  pb_state_e      st_q, st_n;
  logic [CW-1:0]  cnt_q, cnt_n;
  logic           take, dpend_q, dwe_q, dpend_n, dwe_n;
  logic [AW-1:0]  daddr_n, paddr_n;
  logic [DW-1:0]  dwdata_n, pwdata_n;

  pbs_wait_cfg #(.WSW(WSW), .WS_RST(WS_RST)) u_cfg (
    .clk(clk), .rst(rst), .we(ws_we), .wval(ws_val), .ws_q(ws_q)
  );

  pbs_req #(.AW(AW), .DW(DW)) u_req (
    .clk(clk), .rst(rst), .take(take), .pwr_req(pwr_req),
    .dacc_req(dacc_req), .dacc_we(dacc_we), .dacc_addr(dacc_addr),
    .dacc_wdata(dacc_wdata), .fetch_addr(fetch_addr), .pwr_data(pwr_data),
    .dpend_q(dpend_q), .dwe_q(dwe_q), .dpend_n(dpend_n), .dwe_n(dwe_n),
    .daddr_n(daddr_n), .dwdata_n(dwdata_n), .paddr_n(paddr_n), .pwdata_n(pwdata_n)
  );

  pbs_fsm #(.WSW(WSW), .PW_WAITS(PW_WAITS)) u_fsm (
    .clk(clk), .rst(rst), .pwr_req(pwr_req), .dpend_q(dpend_q), .ws_q(ws_q),
    .st_q(st_q), .st_n(st_n), .cnt_q(cnt_q), .cnt_n(cnt_n), .take(take)
  );

  pbs_drive #(.AW(AW), .DW(DW), .WSW(WSW), .PW_WAITS(PW_WAITS), .CW(CW)) u_drv (
    .clk(clk), .rst(rst), .st_q(st_q), .st_n(st_n), .cnt_q(cnt_q), .cnt_n(cnt_n),
    .dwe_q(dwe_q), .dwe_n(dwe_n), .daddr_n(daddr_n), .dwdata_n(dwdata_n),
    .paddr_n(paddr_n), .pwdata_n(pwdata_n), .ext_din(ext_din),
    .ext_addr(ext_addr), .ext_dout(ext_dout), .ext_doe(ext_doe),
    .prog_rd(prog_rd), .prog_wr(prog_wr), .data_rd(data_rd), .data_wr(data_wr),
    .core_stall(core_stall), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  AST_DPEND_EXCL: assert property (@(posedge clk) disable iff (rst)
    (take && pwr_req) |=> !dpend_q); // R6
endmodule

// File: tb/progbus_seq_tb.sv
module progbus_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] fetch_addr = '0, pwr_data = '0, dacc_addr = '0, dacc_wdata = '0, ext_din = '0;
  logic        pwr_req = 1'b0, dacc_req = 1'b0, dacc_we = 1'b0, ws_we = 1'b0;
  logic [2:0]  ws_val = '0;
  logic [15:0] ext_addr, ext_dout, rd_data;
  logic        ext_doe, prog_rd, prog_wr, data_rd, data_wr, core_stall, rd_valid;

  always #10 clk = ~clk;

  progbus_seq dut_i (
    .clk(clk), .rst(rst), .fetch_addr(fetch_addr), .pwr_req(pwr_req), .pwr_data(pwr_data),
    .dacc_req(dacc_req), .dacc_we(dacc_we), .dacc_addr(dacc_addr), .dacc_wdata(dacc_wdata),
    .ws_we(ws_we), .ws_val(ws_val), .ext_din(ext_din), .ext_addr(ext_addr),
    .ext_dout(ext_dout), .ext_doe(ext_doe), .prog_rd(prog_rd), .prog_wr(prog_wr),
    .data_rd(data_rd), .data_wr(data_wr), .core_stall(core_stall),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  typedef struct {
    bit prd, pwr, drd, dwr, doe, stall, rv;
    int addr, dout, kind;
  } exp_t;
  localparam int K_NORM = 0, K_IDLE1 = 1, K_LAST = 2;

  exp_t q[$];
  int   nchk = 0, nbad = 0;
  int   mcfg = 7;
  bit   started = 0, done = 0;
  int   l_da, l_dwd, saved_din;
  bit   l_we;
  int   p_pw = 0, p_d = 0, p_ws = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, expv, $time);
    end
  endtask

  function automatic exp_t mk(bit prd, bit pwr, bit drd, bit dwr, bit doe, bit stall,
                              bit rv, int addr, int dout, int kind);
    exp_t e;
    e.prd = prd; e.pwr = pwr; e.drd = drd; e.dwr = dwr; e.doe = doe;
    e.stall = stall; e.rv = rv; e.addr = addr; e.dout = dout; e.kind = kind;
    return e;
  endfunction

  // reference model: a queue of expected cycles, refilled at sequence-start edges
  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      q.push_back(mk(0,0,0,0,0,1,0,0,0,K_NORM)); // R1 reset cycle
      mcfg = 7;
      started = 1;
    end else if (started) begin
      exp_t cur;
      cur = q.pop_front();
      if (cur.kind == K_LAST) saved_din = int'(ext_din);
      if (cur.kind == K_IDLE1) begin
        for (int i = 0; i <= mcfg; i++)
          q.push_back(mk(0,0,!l_we,l_we,l_we,1,0,l_da,l_dwd,(i == mcfg) ? K_LAST : K_NORM));
        q.push_back(mk(0,0,0,0,0,1,!l_we,0,0,K_NORM));
      end
      if (q.size() == 0) begin
        if (pwr_req) begin
          for (int i = 0; i < 4; i++)
            q.push_back(mk(0,1,0,0,1,(i < 3),0,int'(fetch_addr),int'(pwr_data),K_NORM));
        end else begin
          q.push_back(mk(1,0,0,0,0,0,0,int'(fetch_addr),0,K_NORM));
          if (dacc_req) begin
            l_da = int'(dacc_addr); l_dwd = int'(dacc_wdata); l_we = dacc_we;
            q.push_back(mk(0,0,0,0,0,1,0,0,0,K_IDLE1));
          end
        end
      end
      if (ws_we) mcfg = int'(ws_val);
    end
  end

  always @(negedge clk) begin
    if (started && !done && q.size() > 0) begin
      exp_t e;
      e = q[0];
      chk(core_stall == e.stall, "R5 core_stall", int'(core_stall), int'(e.stall));
      chk(prog_rd == e.prd, "R2 prog_rd", int'(prog_rd), int'(e.prd));
      chk(prog_wr == e.pwr, "R6 prog_wr", int'(prog_wr), int'(e.pwr));
      chk(data_rd == e.drd, "R3 R4 data_rd", int'(data_rd), int'(e.drd));
      chk(data_wr == e.dwr, "R3 R4 data_wr", int'(data_wr), int'(e.dwr));
      chk(ext_doe == e.doe, "R7 ext_doe", int'(ext_doe), int'(e.doe));
      if (e.doe) chk(int'(ext_dout) == e.dout, "R7 ext_dout", int'(ext_dout), e.dout);
      if (e.prd || e.pwr || e.drd || e.dwr)
        chk(int'(ext_addr) == e.addr, "R9 ext_addr", int'(ext_addr), e.addr);
      chk(rd_valid == e.rv, "R8 rd_valid", int'(rd_valid), int'(e.rv));
      if (e.rv) chk(int'(rd_data) == saved_din, "R8 rd_data", int'(rd_data), saved_din);
    end
  end

  // random stimulus, changed away from the active edge
  always @(negedge clk) begin
    fetch_addr <= 16'($urandom);
    pwr_data   <= 16'($urandom);
    dacc_addr  <= 16'($urandom);
    dacc_wdata <= 16'($urandom);
    ext_din    <= 16'($urandom);
    dacc_we    <= 1'($urandom);
    pwr_req    <= ($urandom % 100) < p_pw;
    dacc_req   <= ($urandom % 100) < p_d;
    ws_we      <= ($urandom % 100) < p_ws;
    ws_val     <= 3'($urandom);
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values seen directly
    chk(core_stall == 1'b1, "R1 stall", int'(core_stall), 1);
    chk({prog_rd, prog_wr, data_rd, data_wr, ext_doe, rd_valid} == 6'b0, "R1 strobes",
        int'({prog_rd, prog_wr, data_rd, data_wr, ext_doe, rd_valid}), 0);
    rst = 1'b0;
    repeat (40) @(negedge clk);         // R2 plain fetches
    p_d = 100;
    repeat (200) @(negedge clk);        // R1 R4 default wait of 7
    p_d = 0; p_pw = 100;
    repeat (100) @(negedge clk);        // R6 back-to-back program writes
    p_d = 100; p_pw = 50;
    repeat (300) @(negedge clk);        // R6 data dropped beside program write
    p_pw = 0; p_ws = 30;
    repeat (800) @(negedge clk);        // R4 changing wait counts
    p_pw = 20; p_d = 50; p_ws = 10;
    repeat (2000) @(negedge clk);       // mixed traffic
    done = 1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    #2000000;
    nchk++; nbad++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule